// File: doc/BRIEF.md
# Clock-Supervised System Reset Sequencer

This block produces the system reset and the CPU reset of a low-power controller. Three things raise the system reset: the power-on reset input, a stop of the main (monitored) oscillator while the part is awake, and the external reset pin. The CPU reset follows the system reset. It is then held for a long stabilization hold-off, counted in monitored-clock cycles, so the oscillator can settle. The same hold-off is applied after power-on, after wake from sleep and after the oscillator comes back from a stop.

A free-running reference clock supervises the monitored clock. It counts its own cycles and restarts the count on every synchronized level change of the monitored clock. If the count reaches its limit, the oscillator is declared stopped. Supervision is blanked during sleep and while the hold-off runs. A software-written inhibit bit can also switch it off, and every system reset clears that bit. While awake, the reset pin passes through a digital debouncer clocked by the monitored clock. In sleep there is no clock, so the pin drives the system reset directly.

Top module: `clk_sup_rst_seq`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` and `cpu_rst_o` are high. After `por_i` falls, `cpu_rst_o` stays high for at least HOLD_CYCLES rising edges of `sys_clk_i` and is low by HOLD_CYCLES+4 edges.
- R2: While `sleep_i` is high, `cpu_rst_o` is high. After `sleep_i` falls with the clock running, `cpu_rst_o` stays high for at least HOLD_CYCLES edges of `sys_clk_i` and then falls.
- R3: Awake, with supervision enabled and the hold-off complete, if `sys_clk_i` shows no level change for STOP_LIMIT reference cycles, `sys_rst_o` pulses high. `cpu_rst_o` then stays high until the clock has run again for at least HOLD_CYCLES edges.
- R4: While the hold-off is still counting, a stopped `sys_clk_i` raises no system reset.
- R5: While `sleep_i` is high, a stopped `sys_clk_i` raises no system reset.
- R6: A write on a rising `sys_clk_i` edge with `inh_we_i`=1 and `inh_wd_i`=1 sets the inhibit bit. While it is set, a stopped clock raises no system reset and `cpu_rst_o` stays low.
- R7: Every system reset (power-on, pin or oscillator stop) clears the inhibit bit to 0, so oscillator-stop detection works again after recovery.
- R8: Awake, `rst_pin_i` raises `sys_rst_o` only after it has been seen high on DEB_CYCLES consecutive synchronized samples. Shorter pulses have no effect. `sys_rst_o` falls within 4 clock edges after the pin is released.
- R9: A single low sample during a pin pulse restarts the debounce count. Two high runs that are each shorter than DEB_CYCLES, split by one low cycle, raise no reset.
- R10: While `sleep_i` is high, `rst_pin_i` drives `sys_rst_o` directly, with no clock needed, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| sleep_i | input | 1 | Sleep indication; the monitored oscillator is off while high |
| sys_clk_i | input | 1 | Monitored system clock; times the hold-off and the debounce |
| ref_clk_i | input | 1 | Free-running reference clock for oscillator supervision |
| rst_pin_i | input | 1 | External reset pin, active high, after its analog filter |
| inh_we_i | input | 1 | Write strobe for the supervision inhibit bit (sys_clk_i domain) |
| inh_wd_i | input | 1 | Value written to the inhibit bit; 1 disables supervision |
| sys_rst_o | output | 1 | System reset, active high |
| cpu_rst_o | output | 1 | CPU reset, active high; system reset plus hold-off |

## Verification
The bench stops the monitored clock in four different states: after the hold-off, during it, in sleep and with the inhibit bit set. A detector that was not blanked would fire a spurious reset during the hold-off or in sleep. One that ignored the inhibit bit would reset a running CPU. A design that failed to clear the bit on a pin reset would stay deaf to a real stop. Pin pulses just under and over the debounce length, and a pulse split by one low cycle, catch a debouncer with an off-by-one or without restart. The sleep path checks that the pin acts with no clock. Hold-off windows are bounded on both sides, which catches a hold-off that is too short or one that never ends.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Status handed from the monitored-clock domain to the supervisor.
    typedef struct packed {
        logic hold_done;   // hold-off count complete
        logic inhibit;     // supervision switched off by software
    } rsq_sys_stat_t;

    // Bit order of the vector carried across into the reference domain.
    localparam int XB_CLK   = 0;
    localparam int XB_DONE  = 1;
    localparam int XB_INH   = 2;
    localparam int XB_SLEEP = 3;
    localparam int XB_WIDTH = 4;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    assign chain_d[0] = d;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rsq_holdoff.sv
module rsq_holdoff
    import rsq_pkg::*;
#(
    parameter int HOLD_CYCLES = 32768
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          inh_we,
    input  logic          inh_wd,
    output rsq_sys_stat_t stat
);

    localparam int            CW      = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_TC = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          inh;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.done = (st_d.cnt == HOLD_TC);
        if (inh_we) begin
            st_d.inh = inh_wd;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat.hold_done = st_q.done;
    assign stat.inhibit   = st_q.inh;

    // R1
    hold_done_sticky_chk: assert property (@(posedge clk) disable iff (arst)
        st_q.done |=> st_q.done);

    // R6
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (arst)
        !inh_we |=> $stable(st_q.inh));

    // R6
    inhibit_write_chk: assert property (@(posedge clk) disable iff (arst)
        inh_we |=> (st_q.inh == $past(inh_wd)));

endmodule

// File: rtl/rsq_debounce.sv
module rsq_debounce #(
    parameter int DEB_CYCLES  = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic pin,
    output logic deb
);

    localparam int            CW     = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] DEB_TC = CW'(DEB_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } deb_state_t;

    deb_state_t st_d, st_q;
    logic       pin_s;

    rsq_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_pin_sync (
        .clk  (clk),
        .arst (arst),
        .d    (pin),
        .q    (pin_s)
    );

    always_comb begin
        st_d = st_q;
        if (!pin_s) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != DEB_TC) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.out = (st_d.cnt == DEB_TC);
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign deb = st_q.out;

    // R9
    low_sample_clears_chk: assert property (@(posedge clk) disable iff (arst)
        !pin_s |=> !st_q.out);

    // R8
    rise_needs_pin_chk: assert property (@(posedge clk) disable iff (arst)
        $rose(st_q.out) |-> $past(pin_s));

endmodule

// File: rtl/rsq_osc_mon.sv
module rsq_osc_mon
    import rsq_pkg::*;
#(
    parameter int STOP_LIMIT  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          ref_clk,
    input  logic          arst,
    input  logic          mon_clk,
    input  logic          sleep,
    input  rsq_sys_stat_t stat,
    output logic          stop
);

    localparam int            CW      = $clog2(STOP_LIMIT + 1);
    localparam logic [CW-1:0] STOP_TC = CW'(STOP_LIMIT);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          stop;
    } mon_state_t;

    mon_state_t          st_d, st_q;
    logic [XB_WIDTH-1:0] xin, xs;
    logic                en, edge_seen;

    always_comb begin
        xin           = '0;
        xin[XB_CLK]   = mon_clk;
        xin[XB_DONE]  = stat.hold_done;
        xin[XB_INH]   = stat.inhibit;
        xin[XB_SLEEP] = sleep;
    end

    rsq_sync #(.STAGES(SYNC_STAGES), .WIDTH(XB_WIDTH), .RST_VAL('0)) u_xsync (
        .clk  (ref_clk),
        .arst (arst),
        .d    (xin),
        .q    (xs)
    );

    assign en        = xs[XB_DONE] & ~xs[XB_INH] & ~xs[XB_SLEEP];
    assign edge_seen = xs[XB_CLK] ^ st_q.lvl;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = xs[XB_CLK];
        if (!en || edge_seen) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != STOP_TC) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.stop = en && (st_d.cnt == STOP_TC);
    end

    always_ff @(posedge ref_clk or posedge arst) begin
        if (arst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stop = st_q.stop;

    // R4
    blank_when_disabled_chk: assert property (@(posedge ref_clk) disable iff (arst)
        !en |=> !st_q.stop);

    // R3
    toggle_clears_stop_chk: assert property (@(posedge ref_clk) disable iff (arst)
        edge_seen |=> !st_q.stop);

    // R3
    stop_at_limit_chk: assert property (@(posedge ref_clk) disable iff (arst)
        st_q.stop |-> (st_q.cnt == STOP_TC));

endmodule

// File: rtl/clk_sup_rst_seq.sv
module clk_sup_rst_seq
    import rsq_pkg::*;
#(
    parameter int HOLD_CYCLES = 32768,
    parameter int DEB_CYCLES  = 512,
    parameter int STOP_LIMIT  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic por_i,
    input  logic sleep_i,
    input  logic sys_clk_i,
    input  logic ref_clk_i,
    input  logic rst_pin_i,
    input  logic inh_we_i,
    input  logic inh_wd_i,
    output logic sys_rst_o,
    output logic cpu_rst_o
);

    rsq_sys_stat_t stat;
    logic          stop, pin_deb, pin_rst;
    logic          hold_arst, sys_rst_s;

    // Pin path: debounced while awake, direct in sleep.
    rsq_debounce #(.DEB_CYCLES(DEB_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_deb (
        .clk  (sys_clk_i),
        .arst (por_i),
        .pin  (rst_pin_i),
        .deb  (pin_deb)
    );

    assign pin_rst   = sleep_i ? rst_pin_i : pin_deb;
    assign sys_rst_o = por_i | stop | pin_rst;
    assign hold_arst = sys_rst_o | sleep_i;

    // Reset for the monitored domain: asserts at once, releases on clock edges.
    rsq_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_rst_sync (
        .clk  (sys_clk_i),
        .arst (hold_arst),
        .d    (1'b0),
        .q    (sys_rst_s)
    );

    rsq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (sys_clk_i),
        .arst   (sys_rst_s),
        .inh_we (inh_we_i),
        .inh_wd (inh_wd_i),
        .stat   (stat)
    );

    rsq_osc_mon #(.STOP_LIMIT(STOP_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
        .ref_clk (ref_clk_i),
        .arst    (por_i),
        .mon_clk (sys_clk_i),
        .sleep   (sleep_i),
        .stat    (stat),
        .stop    (stop)
    );

    assign cpu_rst_o = sys_rst_o | ~stat.hold_done;

    // R2
    sleep_holds_cpu_chk: assert property (@(posedge ref_clk_i) disable iff (por_i)
        (sleep_i && $past(sleep_i)) |-> cpu_rst_o);

endmodule

// File: tb/clk_sup_rst_seq_bench.sv
module clk_sup_rst_seq_bench;

    localparam int HOLD = 64;
    localparam int DEB  = 16;
    localparam int NVEC = 5;
    // {expect reset, pin high length in sys_clk cycles}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 8'd4}, {1'b0, 8'd10}, {1'b0, 8'd15}, {1'b1, 8'd20}, {1'b1, 8'd30}
    };

    logic ref_clk = 1'b0, sys_clk = 1'b0, run = 1'b1;
    logic por = 1'b1, sleep = 1'b0, pin = 1'b0, we = 1'b0, wd = 1'b0;
    logic sys_rst, cpu_rst;
    logic seen = 1'b0;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    clk_sup_rst_seq #(.HOLD_CYCLES(HOLD), .DEB_CYCLES(DEB), .STOP_LIMIT(8),
                      .SYNC_STAGES(2)) u_clk_sup_rst_seq (
        .por_i(por), .sleep_i(sleep), .sys_clk_i(sys_clk), .ref_clk_i(ref_clk),
        .rst_pin_i(pin), .inh_we_i(we), .inh_wd_i(wd),
        .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst)
    );

    initial forever #5 ref_clk = ~ref_clk;
    initial forever begin #20; if (run) sys_clk = ~sys_clk; end
    always @(posedge sys_rst) seen = 1'b1;

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic stall();
        run = 1'b0;
        #300;
    endtask

    task automatic restart();
        run = 1'b1;
        cyc(1);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #50;
        chk("R1 sys_rst in por", sys_rst, 1'b1);
        chk("R1 cpu_rst in por", cpu_rst, 1'b1);
        cyc(1);
        por = 1'b0;
        cyc(HOLD);
        chk("R1 hold-off minimum", cpu_rst, 1'b1);
        cyc(4);
        chk("R1 hold-off ends", cpu_rst, 1'b0);

        // R8: pulse length table
        for (int i = 0; i < NVEC; i++) begin
            seen = 1'b0;
            pin = 1'b1;
            cyc(int'(VEC[i][7:0]));
            pin = 1'b0;
            cyc(4);
            chk("R8 debounce vector", seen, VEC[i][8]);
            chk("R8 release", sys_rst, 1'b0);
            cyc(HOLD + 10);
            chk("R8 cpu recovers", cpu_rst, 1'b0);
        end

        // R9: split pulse
        seen = 1'b0;
        pin = 1'b1; cyc(12);
        pin = 1'b0; cyc(1);
        pin = 1'b1; cyc(12);
        pin = 1'b0; cyc(4);
        chk("R9 split pulse ignored", seen, 1'b0);

        // R3: oscillator stop after hold-off
        seen = 1'b0;
        stall();
        chk("R3 stop raises reset", seen, 1'b1);
        chk("R3 cpu held while stopped", cpu_rst, 1'b1);
        restart();
        cyc(HOLD);
        chk("R3 hold-off after restart", cpu_rst, 1'b1);
        cyc(10);
        chk("R3 cpu released", cpu_rst, 1'b0);

        // R4: stop during hold-off
        #3; por = 1'b1; #100; cyc(1); por = 1'b0;
        cyc(10);
        seen = 1'b0;
        stall();
        chk("R4 blanked during hold-off", seen, 1'b0);
        restart();
        cyc(HOLD + 10);
        chk("R4 cpu released", cpu_rst, 1'b0);

        // R6: inhibit bit
        we = 1'b1; wd = 1'b1; cyc(1);
        we = 1'b0; wd = 1'b0; cyc(2);
        seen = 1'b0;
        stall();
        chk("R6 inhibit blocks reset", seen, 1'b0);
        chk("R6 cpu keeps running", cpu_rst, 1'b0);
        restart();
        cyc(4);

        // R7: pin reset clears inhibit
        pin = 1'b1; cyc(DEB + 8);
        pin = 1'b0;
        cyc(HOLD + 12);
        chk("R7 cpu recovered", cpu_rst, 1'b0);
        seen = 1'b0;
        stall();
        chk("R7 inhibit cleared, stop detected", seen, 1'b1);
        restart();
        cyc(HOLD + 10);

        // R2, R5, R10: sleep
        sleep = 1'b1;
        #1;
        chk("R2 cpu held in sleep", cpu_rst, 1'b1);
        #100;
        seen = 1'b0;
        run = 1'b0;
        #400;
        chk("R5 no stop reset in sleep", seen, 1'b0);
        pin = 1'b1; #2;
        chk("R10 pin direct in sleep", sys_rst, 1'b1);
        pin = 1'b0; #2;
        chk("R10 pin release in sleep", sys_rst, 1'b0);
        run = 1'b1;
        cyc(2);
        sleep = 1'b0;
        cyc(HOLD);
        chk("R2 hold-off after wake", cpu_rst, 1'b1);
        cyc(10);
        chk("R2 cpu released after wake", cpu_rst, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule